// File: doc/BRIEF.md
# NRZI Bit-Step Sampler with Marker-Shift Destuffing

This block performs one receive step of a differential serial line each time it is strobed. It reads the two line levels, works out whether the bus is in single-ended-zero, whether the current bit is a stuffed bit, or whether it carries a data bit. It then folds the result into a 32-bit state word and reports the outcome on two registered flags. NRZI decoding compares the level of the J line with the level kept from the previous step. An unchanged level decodes as 1 and a transition decodes as 0. Decoded bits enter the top of a nine-bit accumulator and walk downward, so a framing stage elsewhere can spot a marker bit reaching position 0.

Run-length tracking for destuffing uses no counter. A single marker bit lives in a seven-bit shadow field at the top of the word. A decoded 0 re-plants the marker at the top of the field, and each decoded 1 moves it one place down. When the marker sits in the lowest shadow position, six ones in a row have arrived and the next bit is discarded as stuffing. Software may overwrite the whole word through a load port, for example to preset the previous-level bit to the bus idle state. CRC and byte framing live outside the block.

Each clock the controller is in one of three modes: CTL_LOAD (load_en high, takes priority), CTL_STEP (step_en high) or CTL_HOLD. The registered outcome state takes one of four values, and its encoding is the flag pair {flag_z, flag_c}: OUT_DATA0 (00), OUT_DATA1 (01), OUT_SE0 (10) and OUT_STUFF (11). Only CTL_STEP moves the outcome state. From any outcome it goes to OUT_SE0 when both lines are low. Otherwise it goes to OUT_STUFF when the marker is at the lowest shadow bit. Otherwise it goes to OUT_DATA1 or OUT_DATA0 according to the decoded bit.

Top module: `nrzi_step_unit`

## Requirements
- R1: After reset the state word is 32'h8000_0200, with the marker at bit 31, the previous level 1 and all other bits 0, and both flags are 0.
- R2: When load_en is high, the next clock writes load_word into the state word even if step_en is also high, and leaves the flags unchanged.
- R3: With pair_odd = 0 the J line is pin_pair[0] and the K line is pin_pair[1]; with pair_odd = 1 the two are swapped. The sampled level is the level of the J line.
- R4: A step with both pins low gives flags {z,c} = 10, leaves the state word unchanged, and has priority over the stuffing and data decisions.
- R5: A data step decodes d = ~(bit9 ^ J), writes d into bit 8, moves old bits 8..1 into bits 7..0, and sets flags {z,c} = {0,d}.
- R6: Every step that is not SE0 stores the J level into bit 9.
- R7: The shadow field occupies bits 31..25. A decoded 0 sets it to 7'b1000000, and a decoded 1 shifts it down by one place with 0 entering bit 31.
- R8: A non-SE0 step taken while bit 25 is 1 is a stuffed bit. It gives flags 11, leaves bits 8..0 unchanged, and resets the shadow field to 7'b1000000.
- R9: Steps never change bits 24..10.
- R10: With neither step_en nor load_en high, the state word and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Take one bit step this cycle |
| load_en | input | 1 | Overwrite the state word this cycle |
| load_word | input | 32 | Value written by a load |
| pin_pair | input | 2 | Line levels; bit 0 is the lower-numbered pin |
| pair_odd | input | 1 | Pair orientation: 1 swaps the J and K roles |
| state_word | output | 32 | Current state word |
| flag_z | output | 1 | Upper outcome flag |
| flag_c | output | 1 | Lower outcome flag |

## Verification
The assertions assume that pin_pair is stable and defined around each strobed edge. They also assume that any word loaded while a run is in progress carries at most one marker bit in the shadow field, so that "bit 25 set" really means six ones have been seen. The stimulus changes pins and strobes only on falling edges. It loads only words with a single marker in the shadow field, and it drives SE0 both in ordinary data and at the exact step where a stuffed bit is pending, which exercises the priority of R4 over R8.

// File: rtl/nrzi_step_pkg.sv
package nrzi_step_pkg;

    // Outcome of one step; the encoding is the {z,c} flag pair.
    typedef enum logic [1:0] {
        OUT_DATA0 = 2'b00,
        OUT_DATA1 = 2'b01,
        OUT_SE0   = 2'b10,
        OUT_STUFF = 2'b11
    } step_kind_t;

    // Per-cycle update mode of the state register.
    typedef enum logic [1:0] {
        CTL_HOLD = 2'b00,
        CTL_LOAD = 2'b01,
        CTL_STEP = 2'b10
    } ctl_mode_t;

endpackage

// File: rtl/nrzi_pin_orient.sv
module nrzi_pin_orient (
    input  logic [1:0] pin_pair,
    input  logic       pair_odd,
    output logic       j_line,
    output logic       k_line
);

    // Even pair: J on the lower pin; odd pair: J on the upper pin.
    always_comb begin
        if (pair_odd) begin
            j_line = pin_pair[1];
            k_line = pin_pair[0];
        end else begin
            j_line = pin_pair[0];
            k_line = pin_pair[1];
        end
    end

endmodule

// File: rtl/nrzi_step_classify.sv
module nrzi_step_classify
    import nrzi_step_pkg::*;
(
    input  logic       j_line,
    input  logic       k_line,
    input  logic       prev_level,
    input  logic       stuff_pending,
    output step_kind_t kind,
    output logic       data_bit
);

    logic se0;

    always_comb begin
        se0      = ~j_line & ~k_line;
        data_bit = ~(prev_level ^ j_line);
        unique case ({se0, stuff_pending})
            2'b10, 2'b11: kind = OUT_SE0;
            2'b01:        kind = OUT_STUFF;
            2'b00:        kind = data_bit ? OUT_DATA1 : OUT_DATA0;
            default:      kind = OUT_SE0;
        endcase
    end

endmodule

// File: rtl/nrzi_word_next.sv
module nrzi_word_next
    import nrzi_step_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int SHADOW_W = 7,
    parameter int ACC_W    = 9,
    parameter int PREV_POS = 9
) (
    input  logic [WORD_W-1:0] word_in,
    input  step_kind_t        kind,
    input  logic              level,
    input  logic              data_bit,
    output logic [WORD_W-1:0] word_out
);

    localparam int SHADOW_LSB = WORD_W - SHADOW_W;
    localparam logic [SHADOW_W-1:0] MARK = {1'b1, {(SHADOW_W-1){1'b0}}};

    logic [SHADOW_W-1:0] shadow_in;

    always_comb begin
        shadow_in = word_in[WORD_W-1:SHADOW_LSB];
        word_out  = word_in;
        unique case (kind)
            OUT_SE0: begin
                word_out = word_in;
            end
            OUT_STUFF: begin
                word_out[PREV_POS]                = level;
                word_out[WORD_W-1:SHADOW_LSB]     = MARK;
            end
            OUT_DATA0, OUT_DATA1: begin
                word_out[PREV_POS]                = level;
                word_out[ACC_W-1:0]               = {data_bit, word_in[ACC_W-1:1]};
                word_out[WORD_W-1:SHADOW_LSB]     = data_bit ? (shadow_in >> 1) : MARK;
            end
            default: begin
                word_out = word_in;
            end
        endcase
    end

endmodule

// File: rtl/nrzi_step_unit.sv
module nrzi_step_unit
    import nrzi_step_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int SHADOW_W   = 7,
    parameter int ACC_W      = 9,
    parameter int PREV_POS   = 9,
    parameter bit IDLE_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    input  logic [1:0]        pin_pair,
    input  logic              pair_odd,
    output logic [WORD_W-1:0] state_word,
    output logic              flag_z,
    output logic              flag_c
);

    localparam int SHADOW_LSB = WORD_W - SHADOW_W;
    localparam int MID_LSB    = PREV_POS + 1;
    localparam logic [SHADOW_W-1:0] MARK = {1'b1, {(SHADOW_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] RESET_WORD =
        ({{(WORD_W-SHADOW_W){1'b0}}, MARK} << SHADOW_LSB) |
        ({{(WORD_W-1){1'b0}}, IDLE_LEVEL} << PREV_POS);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_nxt;
    step_kind_t        kind_q;
    step_kind_t        kind_d;
    ctl_mode_t         ctl;
    logic              j_line;
    logic              k_line;
    logic              data_bit;

    nrzi_pin_orient u_orient (
        .pin_pair (pin_pair),
        .pair_odd (pair_odd),
        .j_line   (j_line),
        .k_line   (k_line)
    );

    nrzi_step_classify u_classify (
        .j_line        (j_line),
        .k_line        (k_line),
        .prev_level    (word_q[PREV_POS]),
        .stuff_pending (word_q[SHADOW_LSB]),
        .kind          (kind_d),
        .data_bit      (data_bit)
    );

    nrzi_word_next #(
        .WORD_W   (WORD_W),
        .SHADOW_W (SHADOW_W),
        .ACC_W    (ACC_W),
        .PREV_POS (PREV_POS)
    ) u_next (
        .word_in  (word_q),
        .kind     (kind_d),
        .level    (j_line),
        .data_bit (data_bit),
        .word_out (word_nxt)
    );

    always_comb begin
        if (load_en)      ctl = CTL_LOAD;
        else if (step_en) ctl = CTL_STEP;
        else              ctl = CTL_HOLD;
    end

    // State register: word and outcome state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RESET_WORD;
            kind_q <= OUT_DATA0;
        end else begin
            unique case (ctl)
                CTL_LOAD: word_q <= load_word;
                CTL_STEP: begin
                    word_q <= word_nxt;
                    kind_q <= kind_d;
                end
                CTL_HOLD: ;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        state_word = word_q;
        flag_z     = kind_q[1];
        flag_c     = kind_q[0];
    end

    // R4
    se0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && pin_pair == 2'b00) |=>
        (flag_z && !flag_c && $stable(word_q)));

    // R8
    stuff_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && pin_pair != 2'b00 && word_q[SHADOW_LSB]) |=>
        (flag_z && flag_c && word_q[WORD_W-1] &&
         word_q[ACC_W-1:0] == $past(word_q[ACC_W-1:0])));

    // R5
    accept_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && pin_pair != 2'b00 && !word_q[SHADOW_LSB]) |=>
        (!flag_z && word_q[ACC_W-1] == flag_c &&
         word_q[ACC_W-2:0] == $past(word_q[ACC_W-1:1])));

    // R6
    prev_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && pin_pair != 2'b00) |=>
        (word_q[PREV_POS] == $past(j_line)));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (word_q == $past(load_word) && $stable(kind_q)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> ($stable(word_q) && $stable(kind_q)));

    // R9
    mid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> $stable(word_q[SHADOW_LSB-1:MID_LSB]));

endmodule

// File: tb/nrzi_step_unit_bench.sv
module nrzi_step_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_en;
    logic        load_en;
    logic [31:0] load_word;
    logic [1:0]  pin_pair;
    logic        pair_odd;
    logic [31:0] state_word;
    logic        flag_z;
    logic        flag_c;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nrzi_step_unit u_nrzi_step_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .load_en    (load_en),
        .load_word  (load_word),
        .pin_pair   (pin_pair),
        .pair_odd   (pair_odd),
        .state_word (state_word),
        .flag_z     (flag_z),
        .flag_c     (flag_c)
    );

    // {pair_odd, pin_pair[1:0], expected z, expected c}
    localparam logic [4:0] VEC [15] = '{
        5'b0_01_01, 5'b0_10_00, 5'b0_10_01, 5'b0_10_01, 5'b0_10_01,
        5'b0_10_01, 5'b0_10_01, 5'b0_10_01, 5'b0_00_10, 5'b0_01_11,
        5'b0_01_01, 5'b0_00_10, 5'b0_10_00, 5'b1_10_00, 5'b1_10_01
    };

    localparam logic [31:0] MID_MASK = 32'h01FF_FC00;
    localparam logic [31:0] START    = 32'h8000_0200 | (32'h0135_7800 & MID_MASK);

    // Requirement-level model: returns {z, c, next word}.
    function automatic logic [33:0] ref_step(logic [31:0] w, logic [1:0] p, logic o);
        logic        j;
        logic        d;
        logic [31:0] nw;
        j  = o ? p[1] : p[0];
        nw = w;
        if (p == 2'b00) return {2'b10, w};
        nw[9] = j;
        if (w[25]) begin
            nw[31:25] = 7'b1000000;
            return {2'b11, nw};
        end
        d = ~(w[9] ^ j);
        nw[8:0]   = {d, w[8:1]};
        nw[31:25] = d ? {1'b0, w[31:26]} : 7'b1000000;
        return {1'b0, d, nw};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_step(logic [1:0] p, logic o);
        @(negedge clk);
        pin_pair = p;
        pair_odd = o;
        step_en  = 1'b1;
        @(negedge clk);
        step_en  = 1'b0;
    endtask

    task automatic do_load(logic [31:0] v, logic with_step);
        @(negedge clk);
        load_word = v;
        load_en   = 1'b1;
        step_en   = with_step;
        pin_pair  = 2'b01;
        @(negedge clk);
        load_en   = 1'b0;
        step_en   = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] model_w;
        logic [33:0] r;
        rst_n = 1'b0; step_en = 1'b0; load_en = 1'b0;
        load_word = '0; pin_pair = 2'b01; pair_odd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 word", state_word, 32'h8000_0200);
        check("R1 flags", {30'd0, flag_z, flag_c}, 32'd0);

        // R2: load wins over a simultaneous step, flags untouched
        do_load(32'h0000_01FF, 1'b1);
        check("R2 word", state_word, 32'h0000_01FF);
        check("R2 flags", {30'd0, flag_z, flag_c}, 32'd0);

        // R10: no strobe, nothing moves
        @(negedge clk);
        pin_pair = 2'b10;
        @(negedge clk);
        check("R10 hold", state_word, 32'h0000_01FF);

        // Vector walk: R3 R4 R5 R6 R7 R8
        do_load(START, 1'b0);
        model_w = START;
        for (int i = 0; i < 15; i++) begin
            do_step(VEC[i][3:2], VEC[i][4]);
            r = ref_step(model_w, VEC[i][3:2], VEC[i][4]);
            model_w = r[31:0];
            check("R3/R4/R5/R8 flags", {30'd0, flag_z, flag_c}, {30'd0, VEC[i][1:0]});
            check("R5/R6/R7/R8 word", state_word, model_w);
        end

        // R9
        check("R9 middle bits", state_word & MID_MASK, START & MID_MASK);

        // R10: flags also hold without a step
        repeat (2) @(negedge clk);
        check("R10 flags", {30'd0, flag_z, flag_c}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule